// File: doc/BRIEF.md
# Serial Flash Page Program Stager

This block sits behind the serial shifter of a flash memory model and handles the page-program path. The upstream logic decodes the opcode and assembles the bits. It then hands this block four things: a start strobe that says whether the transfer is single-lane or four-lane, a strobe when the 24-bit address is complete, one strobe per data byte, and a flag saying whether the bit count is on a byte boundary. The block stages the data in a 256-byte page buffer. No memory byte changes while chip select is low.

When chip select is released on a byte boundary, the block commits the staged page to its byte array if the target 64 KiB sector is not locked. The commit ANDs each staged byte into memory, so programming can only turn ones into zeros. It walks the page one byte per clock. At the start of the walk it pulses a request to clear the write-enable latch and starts the write-in-progress timer. While the walk runs, any new program command is ignored. A combinational read port lets the surrounding model read the array.

Top module: `flash_pp_buffer`

## Requirements
- R1: After reset every memory byte reads 0xFF, and `wip`, `busy`, `wel_clr` and `data_quad` are low.
- R2: When the address completes, every staged byte becomes 0xFF, so page bytes that receive no data in the current transfer keep their memory value even when an earlier transfer left other data in the buffer.
- R3: Data bytes are placed at the page offset given by address bits [7:0]. The offset then steps by one modulo 256, and address bits [23:8] stay fixed, so a run that crosses offset 0xFF wraps to offset 0x00 of the same page.
- R4: No memory byte changes before chip select rises.
- R5: A commit stores the AND of the old memory byte and the staged byte, so bits can only be cleared.
- R6: A commit starts on the clock edge that sees `cs_n` go high. After that edge, `wel_clr` is high for exactly one cycle and `wip` is high for exactly PROG_CYCLES cycles.
- R7: No commit takes place (memory unchanged, no `wel_clr`, no `wip`) when `lock_bits[addr[23:16]]` was 1 at address capture. A lock bit on another sector has no effect.
- R8: No commit takes place when `bits_aligned` is low on the edge where chip select rises.
- R9: `data_quad` goes high after address capture for a start with `pp_quad`=1, stays low for `pp_quad`=0, and drops when chip select rises.
- R10: `busy` stays high for exactly 256 cycles after the commit edge. A start strobe arriving during that time is ignored, together with the address, data and chip-select release that follow it.
- R11: Releasing chip select before the address completes causes no commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| pp_start | input | 1 | Page-program opcode accepted (one-cycle strobe) |
| pp_quad | input | 1 | Opcode is the four-lane variant |
| addr_valid | input | 1 | Address field complete (one-cycle strobe) |
| addr | input | 24 | Captured address |
| byte_valid | input | 1 | Data byte complete (one-cycle strobe) |
| byte_data | input | 8 | Data byte |
| bits_aligned | input | 1 | Transfer bit count is a multiple of 8 |
| lock_bits | input | 256 | Lock bit per 64 KiB sector, indexed by addr[23:16] |
| rd_addr | input | MEM_AW | Memory read address |
| rd_data | output | 8 | Memory read data |
| data_quad | output | 1 | Shifter should take data four bits per clock |
| wel_clr | output | 1 | One-cycle request to clear write enable |
| wip | output | 1 | Write in progress |
| busy | output | 1 | Commit walk running |

## Verification
The assertions rely on the upstream shifter raising `addr_valid` and `byte_valid` only while `cs_n` is low, and only once the start strobe has been seen. They also rely on `bits_aligned` being valid in the cycle chip select rises. The check that `wip` covers the whole walk is built only when PROG_CYCLES exceeds the page size. The bench drives every strobe for a single cycle, with chip select held low, between a start and a release. It samples on the falling edge, and it waits for `wip` to clear before starting the next transfer, except in the scenario that deliberately issues a start during the walk.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int ADDR_W     = 24;
  localparam int PAGE_BYTES = 256;
  localparam int SECTOR_LSB = 16;

  typedef enum logic [1:0] {
    PP_IDLE = 2'd0,
    PP_ADDR = 2'd1,
    PP_DATA = 2'd2
  } pp_state_e;
endpackage

// File: rtl/fpb_stage_buf.sv
module fpb_stage_buf #(
  parameter int PAGE_BYTES = 256,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             preset,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] stage_q [PAGE_BYTES];

  // Staging flops: whole-page preset at address capture, one byte per strobe.
  always_ff @(posedge clk) begin
    if (preset) begin
      for (int i = 0; i < PAGE_BYTES; i++) stage_q[i] <= 8'hFF;
    end else if (wr_en) begin
      stage_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = stage_q[rd_idx];
endmodule

// File: rtl/fpb_commit_walker.sv
module fpb_commit_walker #(
  parameter int PAGE_BYTES = 256,
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (!busy_q && go) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + IDX_W'(1);
      if (idx_q == LAST_IDX) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (busy_q || go) idx_q <= idx_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;

  // R10: the walk visits page offsets in strict ascending order
  a_r10_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (idx_q == $past(idx_q) + IDX_W'(1)));
endmodule

// File: rtl/fpb_busy_timer.sv
module fpb_busy_timer #(
  parameter int PROG_CYCLES = 300,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic wip
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = CNT_W'(PROG_CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load || cnt_q != '0)  cnt_q <= cnt_d;
  end

  assign wip = (cnt_q != '0);

  // R6: the count never rises except on a load
  a_r6_timer_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/fpb_page_mem.sv
module fpb_page_mem #(
  parameter int MEM_AW = 10,
  localparam int MEM_BYTES = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0] mem_q [MEM_BYTES];
  logic [7:0] cur_byte;

  assign cur_byte = mem_q[wr_addr];

  // Erased state at reset; programming ANDs into the addressed byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (wr_en) begin
      mem_q[wr_addr] <= cur_byte & wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R5: a write never sets a bit that was clear
  a_r5_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem_q[$past(wr_addr)] & ~$past(cur_byte)) == 8'h00));
endmodule

// File: rtl/flash_pp_buffer.sv
module flash_pp_buffer
  import fpb_pkg::*;
#(
  parameter int MEM_AW      = 10,
  parameter int PROG_CYCLES = 300,
  localparam int IDX_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = MEM_AW - IDX_W,
  localparam int LOCK_N = 1 << (ADDR_W - SECTOR_LSB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              pp_start,
  input  logic              pp_quad,
  input  logic              addr_valid,
  input  logic [23:0]       addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              bits_aligned,
  input  logic [LOCK_N-1:0] lock_bits,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              data_quad,
  output logic              wel_clr,
  output logic              wip,
  output logic              busy
);
  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  pp_state_e        st_q, st_d;
  logic             quad_q, quad_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             lock_q, lock_d;
  logic             cs_q;
  logic             wel_q;
  logic             cs_rise, commit_go, preset, buf_wr;
  logic             walk_busy;
  logic [IDX_W-1:0] walk_idx;
  logic [7:0]       stage_byte;
  logic             unused_addr;

  assign unused_addr = ^addr;
  assign cs_rise     = cs_n && !cs_q;
  assign preset      = (st_q == PP_ADDR) && addr_valid && !cs_rise;
  assign buf_wr      = (st_q == PP_DATA) && byte_valid && !cs_rise;
  assign commit_go   = cs_rise && (st_q == PP_DATA) && bits_aligned && !lock_q;

  always_comb begin
    st_d   = st_q;
    quad_d = quad_q;
    page_d = page_q;
    ptr_d  = ptr_q;
    lock_d = lock_q;
    unique case (st_q)
      PP_IDLE: begin
        if (pp_start && !cs_n && !walk_busy) begin
          st_d   = PP_ADDR;
          quad_d = pp_quad;
        end
      end
      PP_ADDR: begin
        if (cs_rise) begin
          st_d = PP_IDLE;
        end else if (addr_valid) begin
          st_d   = PP_DATA;
          page_d = addr[MEM_AW-1:IDX_W];
          ptr_d  = addr[IDX_W-1:0];
          lock_d = lock_bits[addr[ADDR_W-1:SECTOR_LSB]];
        end
      end
      PP_DATA: begin
        if (cs_rise)         st_d  = PP_IDLE;
        else if (byte_valid) ptr_d = ptr_q + IDX_W'(1);
      end
      default: st_d = PP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= PP_IDLE;
      quad_q <= 1'b0;
      page_q <= '0;
      ptr_q  <= '0;
      lock_q <= 1'b0;
      cs_q   <= 1'b1;
      wel_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cs_q  <= cs_n;
      wel_q <= commit_go;
      if (st_q == PP_IDLE) quad_q <= quad_d;
      if (preset) begin
        page_q <= page_d;
        lock_q <= lock_d;
      end
      if (preset || buf_wr) ptr_q <= ptr_d;
    end
  end

  fpb_stage_buf #(.PAGE_BYTES(PAGE_BYTES)) u_stage (
    .clk     (clk),
    .preset  (preset),
    .wr_en   (buf_wr),
    .wr_idx  (ptr_q),
    .wr_data (byte_data),
    .rd_idx  (walk_idx),
    .rd_data (stage_byte)
  );

  fpb_commit_walker #(.PAGE_BYTES(PAGE_BYTES)) u_walk (
    .clk   (clk),
    .rst_n (rst_s),
    .go    (commit_go),
    .busy  (walk_busy),
    .idx   (walk_idx)
  );

  fpb_busy_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_s),
    .load  (commit_go),
    .wip   (wip)
  );

  fpb_page_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (walk_busy),
    .wr_addr ({page_q, walk_idx}),
    .wr_data (stage_byte),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign data_quad = quad_q && (st_q == PP_DATA);
  assign wel_clr   = wel_q;
  assign busy      = walk_busy;

  // R3: each accepted data byte advances the page offset by one, modulo 256
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_s)
    buf_wr |=> (ptr_q == $past(ptr_q) + IDX_W'(1)));
  // R6: the write-enable clear request coincides with the first walk cycle
  a_r6_wel_with_walk: assert property (@(posedge clk) disable iff (!rst_s)
    wel_q |-> (walk_busy && wip));
  // R7: a commit never follows capture of a locked sector
  a_r7_lock_blocks: assert property (@(posedge clk) disable iff (!rst_s)
    wel_q |-> !$past(lock_q));
  // R8: a commit only follows a byte-aligned release
  a_r8_aligned_only: assert property (@(posedge clk) disable iff (!rst_s)
    wel_q |-> $past(bits_aligned));
  // R9: four-lane data mode only ever begins at address capture
  a_r9_quad_at_addr: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(data_quad) |-> $past(addr_valid));
  // R10: no command can be in progress while the walk runs
  a_r10_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_s)
    walk_busy |-> (st_q == PP_IDLE));

  generate
    if (PROG_CYCLES > PAGE_BYTES) begin : g_wip_cover
      // R6: write-in-progress spans the whole walk
      a_r6_wip_covers_walk: assert property (@(posedge clk) disable iff (!rst_s)
        walk_busy |-> wip);
    end
  endgenerate
endmodule

// File: tb/test_flash_pp_buffer.sv
module test_flash_pp_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 10;
  localparam int PROG       = 300;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_n, pp_start, pp_quad, addr_valid, byte_valid, bits_aligned;
  logic [23:0]       addr;
  logic [7:0]        byte_data;
  logic [255:0]      lock_bits;
  logic [MEM_AW-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              data_quad, wel_clr, wip, busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pp_buffer #(.MEM_AW(MEM_AW), .PROG_CYCLES(PROG)) i_flash_pp_buffer (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pp_start(pp_start), .pp_quad(pp_quad),
    .addr_valid(addr_valid), .addr(addr), .byte_valid(byte_valid), .byte_data(byte_data),
    .bits_aligned(bits_aligned), .lock_bits(lock_bits), .rd_addr(rd_addr),
    .rd_data(rd_data), .data_quad(data_quad), .wel_clr(wel_clr), .wip(wip), .busy(busy)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_mem(input string req, input int a, input int exp);
    rd_addr = a[MEM_AW-1:0];
    #1;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic begin_prog(input bit quad);
    cs_n = 1'b0; tick();
    pp_start = 1'b1; pp_quad = quad; tick();
    pp_start = 1'b0; pp_quad = 1'b0;
  endtask

  task automatic send_addr(input logic [23:0] a);
    addr = a; addr_valid = 1'b1; tick();
    addr_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_data = b; byte_valid = 1'b1; tick();
    byte_valid = 1'b0;
  endtask

  task automatic end_cs(input bit aligned);
    bits_aligned = aligned; cs_n = 1'b1; tick();
    bits_aligned = 1'b1;
  endtask

  task automatic settle();
    repeat (PROG + 4) tick();
  endtask

  task automatic t_reset();
    chk_mem("R1 mem[0]", 0, 8'hFF);
    chk_mem("R1 mem[top]", (1 << MEM_AW) - 1, 8'hFF);
    chk("R1 wip", int'(wip), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 wel_clr", int'(wel_clr), 0);
    chk("R1 data_quad", int'(data_quad), 0);
  endtask

  task automatic t_wrap_and_timing();
    begin_prog(1'b0);
    send_addr(24'h0000FE);
    chk("R9 single lane", int'(data_quad), 0);
    send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3); send_byte(8'hD4);
    chk_mem("R4 before release", 'h0FE, 8'hFF);
    chk_mem("R4 before release wrap", 'h000, 8'hFF);
    end_cs(1'b1);
    chk("R6 wel_clr pulse", int'(wel_clr), 1);
    chk("R6 wip set", int'(wip), 1);
    chk("R10 busy set", int'(busy), 1);
    tick();
    chk("R6 wel_clr one cycle", int'(wel_clr), 0);
    repeat (254) tick();
    chk("R10 busy at 255", int'(busy), 1);
    tick();
    chk("R10 busy off at 256", int'(busy), 0);
    repeat (PROG - 1 - 256) tick();
    chk("R6 wip at PROG-1", int'(wip), 1);
    tick();
    chk("R6 wip off at PROG", int'(wip), 0);
    chk_mem("R3 offset FE", 'h0FE, 8'hA1);
    chk_mem("R3 offset FF", 'h0FF, 8'hB2);
    chk_mem("R3 wrap 00", 'h000, 8'hC3);
    chk_mem("R3 wrap 01", 'h001, 8'hD4);
    chk_mem("R3 untouched 02", 'h002, 8'hFF);
    chk_mem("R3 next page untouched", 'h100, 8'hFF);
  endtask

  task automatic t_preset();
    begin_prog(1'b0);
    send_addr(24'h000100);
    send_byte(8'h5A);
    end_cs(1'b1);
    settle();
    chk_mem("R2 written byte", 'h100, 8'h5A);
    chk_mem("R2 stale idx1", 'h101, 8'hFF);
    chk_mem("R2 stale idxFE", 'h1FE, 8'hFF);
  endtask

  task automatic t_and();
    begin_prog(1'b0);
    send_addr(24'h000000);
    send_byte(8'h0F); send_byte(8'hF0);
    end_cs(1'b1);
    settle();
    chk_mem("R5 C3 and 0F", 'h000, 8'h03);
    chk_mem("R5 D4 and F0", 'h001, 8'hD0);
    chk_mem("R5 FE untouched", 'h0FE, 8'hA1);
  endtask

  task automatic t_lock();
    lock_bits = '0;
    lock_bits[1] = 1'b1;
    begin_prog(1'b0);
    send_addr(24'h010300);
    send_byte(8'h11);
    end_cs(1'b1);
    chk("R7 no wel_clr", int'(wel_clr), 0);
    chk("R7 no wip", int'(wip), 0);
    settle();
    chk_mem("R7 locked unchanged", 'h300, 8'hFF);
    begin_prog(1'b0);
    send_addr(24'h000300);
    send_byte(8'h22);
    end_cs(1'b1);
    chk("R7 other sector commits", int'(wel_clr), 1);
    settle();
    chk_mem("R7 other sector written", 'h300, 8'h22);
    lock_bits = '0;
  endtask

  task automatic t_misalign();
    begin_prog(1'b0);
    send_addr(24'h000280);
    send_byte(8'h77);
    end_cs(1'b0);
    chk("R8 no wel_clr", int'(wel_clr), 0);
    chk("R8 no wip", int'(wip), 0);
    settle();
    chk_mem("R8 unchanged", 'h280, 8'hFF);
  endtask

  task automatic t_early_release();
    begin_prog(1'b0);
    end_cs(1'b1);
    chk("R11 no wel_clr", int'(wel_clr), 0);
    chk("R11 no wip", int'(wip), 0);
  endtask

  task automatic t_quad();
    begin_prog(1'b1);
    chk("R9 low before addr", int'(data_quad), 0);
    send_addr(24'h0003C0);
    chk("R9 high after addr", int'(data_quad), 1);
    send_byte(8'h66);
    end_cs(1'b1);
    chk("R9 low after release", int'(data_quad), 0);
    settle();
    chk_mem("R9 quad data stored", 'h3C0, 8'h66);
  endtask

  task automatic t_busy_block();
    begin_prog(1'b0);
    send_addr(24'h000380);
    send_byte(8'h44);
    end_cs(1'b1);
    tick();
    begin_prog(1'b1);
    send_addr(24'h000340);
    chk("R10 start ignored, no quad", int'(data_quad), 0);
    send_byte(8'h99);
    end_cs(1'b1);
    chk("R10 no second commit", int'(wel_clr), 0);
    settle();
    chk_mem("R10 first commit", 'h380, 8'h44);
    chk_mem("R10 ignored data", 'h340, 8'hFF);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; pp_start = 1'b0; pp_quad = 1'b0;
    addr_valid = 1'b0; addr = '0; byte_valid = 1'b0; byte_data = '0;
    bits_aligned = 1'b1; lock_bits = '0; rd_addr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_wrap_and_timing();
    t_preset();
    t_and();
    t_lock();
    t_misalign();
    t_early_release();
    t_quad();
    t_busy_block();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule